// File: doc/BRIEF.md
# Horizontal Pixel Repeat Enable Generator

This block decides, on every pixel clock, whether the video address counter moves on to the next pixel or repeats the current one. A 12-bit ring of flip-flops circulates a pattern that the host writes in one go, and a single fixed tap of that ring acts as the count enable of a 19-bit address counter. A ring holding a one in every Nth position repeats each pixel N times, so the same hardware covers repeat factors of 1, 2, 3, 4 and 6, all of which divide 12. No divider is needed.

The host changes the factor by pulsing a load strobe with a new 12-bit word. The whole ring is replaced at the next clock edge. At the start of every scan line the display timing pulses a line-start input, and the counter jumps to the line's base address. Bit 0 of the ring is the tap. The ring rotates toward that tap, so bit k of a loaded word reaches the tap k clocks after the load edge.

Top module: `pxs_stretch_top`

## Requirements
- R1: During and immediately after synchronous reset, the ring holds all ones, `adv_en` is 1 and `pix_addr` is 0.
- R2: On a clock edge with `load_stb` high, the entire ring takes `load_pat` at once, and `adv_en` in the following cycle equals `load_pat[0]`.
- R3: With no load, the ring rotates one place per clock toward bit 0, and bit 0 wraps around to bit 11. `k` cycles after a load edge, `adv_en` equals `load_pat[k mod 12]`.
- R4: On an edge without `line_start`, `pix_addr` increases by one if `adv_en` was 1 before the edge. Otherwise it keeps its value.
- R5: On an edge with `line_start` high, `pix_addr` takes `line_base`. This takes priority over any advance.
- R6: Loading 0xFFF, 0x555, 0x249, 0x111 or 0x041 holds every address after the first for exactly 1, 2, 3, 4 or 6 clocks respectively.
- R7: `pix_addr` wraps from 0x7FFFF to 0 when it advances.
- R8: A load and a line start on the same edge both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| load_stb | input | 1 | Replace the ring with `load_pat` at the next edge |
| load_pat | input | 12 | Repeat pattern written by the host; bit 0 reaches the tap first |
| line_start | input | 1 | Reload the address counter with `line_base` |
| line_base | input | 19 | First pixel address of the line |
| adv_en | output | 1 | Count enable taken from ring bit 0 |
| pix_addr | output | 19 | Current video pixel address |

## Verification
The bench drives each of the five repeat words and measures how long every address is held. A design with the wrong tap, the wrong rotation direction or an off-by-one hold would produce runs of the wrong length. A mid-run load of an irregular word checks that all twelve bits move together and reach the tap in order; a design that loaded bits one at a time or rotated the other way would show a scrambled enable sequence. Line starts placed on advancing cycles, and a start base just below the top of the address range, check priority and wrap. A design that let the advance win would be off by one from the base, and one with a short counter would wrap at the wrong place.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

    localparam int RING_W = 12;
    localparam int ADDR_W = 19;

    typedef enum logic [2:0] {
        REP_X1 = 3'd1,
        REP_X2 = 3'd2,
        REP_X3 = 3'd3,
        REP_X4 = 3'd4,
        REP_X6 = 3'd6
    } rep_factor_e;

    typedef struct packed {
        logic              load;
        logic [RING_W-1:0] pat;
    } ring_ctrl_t;

    typedef struct packed {
        logic              restart;
        logic [ADDR_W-1:0] base;
        logic              step;
    } addr_ctrl_t;

    // Pattern with a one every n-th bit, starting at bit 0.
    function automatic logic [RING_W-1:0] rep_pattern(input int n);
        logic [RING_W-1:0] p;
        p = '0;
        for (int i = 0; i < RING_W; i++) begin
            if (n > 0 && (i % n) == 0) p[i] = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/pxs_ring_cell.sv
module pxs_ring_cell (
    input  logic clk,
    input  logic rst,
    input  logic rst_val,
    input  logic load,
    input  logic load_bit,
    input  logic prev_bit,
    output logic q
);
    logic d;

    // 2:1 choice between host value and neighbour value
    always_comb d = load ? load_bit : prev_bit;

    always_ff @(posedge clk) begin
        if (rst) q <= rst_val;
        else     q <= d;
    end
endmodule

// File: rtl/pxs_ring.sv
module pxs_ring
    import pxs_pkg::*;
#(
    parameter int W = RING_W,
    parameter logic [W-1:0] RESET_PAT = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst,
    input  ring_ctrl_t   ctrl,
    output logic [W-1:0] ring_q
);
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_cell
            localparam int NXT = (g + 1) % W;
            pxs_ring_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .rst_val  (RESET_PAT[g]),
                .load     (ctrl.load),
                .load_bit (ctrl.pat[g]),
                .prev_bit (ring_q[NXT]),
                .q        (ring_q[g])
            );
        end
    endgenerate
endmodule

// File: rtl/pxs_addr_ctr.sv
module pxs_addr_ctr
    import pxs_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  addr_ctrl_t    ctrl,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_nxt;

    always_comb begin
        addr_nxt = addr;
        if (ctrl.restart)   addr_nxt = ctrl.base;
        else if (ctrl.step) addr_nxt = addr + AW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) addr <= '0;
        else     addr <= addr_nxt;
    end
endmodule

// File: rtl/pxs_stretch_top.sv
module pxs_stretch_top
    import pxs_pkg::*;
#(
    parameter int TAP = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_stb,
    input  logic [RING_W-1:0] load_pat,
    input  logic              line_start,
    input  logic [ADDR_W-1:0] line_base,
    output logic              adv_en,
    output logic [ADDR_W-1:0] pix_addr
);
    localparam logic [RING_W-1:0] RST_PAT = rep_pattern(1);

    ring_ctrl_t        rctl;
    addr_ctrl_t        actl;
    logic [RING_W-1:0] ring_q;

    always_comb begin
        rctl.load = load_stb;
        rctl.pat  = load_pat;
    end

    pxs_ring #(
        .W         (RING_W),
        .RESET_PAT (RST_PAT)
    ) u_ring (
        .clk    (clk),
        .rst    (rst),
        .ctrl   (rctl),
        .ring_q (ring_q)
    );

    always_comb adv_en = ring_q[TAP];

    always_comb begin
        actl.restart = line_start;
        actl.base    = line_base;
        actl.step    = adv_en;
    end

    pxs_addr_ctr #(
        .AW (ADDR_W)
    ) u_addr (
        .clk  (clk),
        .rst  (rst),
        .ctrl (actl),
        .addr (pix_addr)
    );
endmodule

// File: rtl/pxs_stretch_chk.sv
module pxs_stretch_chk
    import pxs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load_stb,
    input logic [RING_W-1:0] load_pat,
    input logic              line_start,
    input logic [ADDR_W-1:0] line_base,
    input logic              adv_en,
    input logic [ADDR_W-1:0] pix_addr,
    input logic [RING_W-1:0] ring_q
);
    AST_RESET_STATE: assert property (@(posedge clk) $fell(rst) |-> (adv_en && pix_addr == '0)); // R1
    AST_LOAD_TAP:    assert property (@(posedge clk) disable iff (rst) load_stb |=> (adv_en == $past(load_pat[0]))); // R2
    AST_LOAD_ALL:    assert property (@(posedge clk) disable iff (rst) load_stb |=> (ring_q == $past(load_pat))); // R8
    AST_ROTATE:      assert property (@(posedge clk) disable iff (rst) !load_stb |=> (ring_q == {$past(ring_q[0]), $past(ring_q[RING_W-1:1])})); // R3
    AST_ONES_KEEP:   assert property (@(posedge clk) disable iff (rst) !load_stb |=> ($countones(ring_q) == $countones($past(ring_q)))); // R3
    AST_ADDR_HOLD:   assert property (@(posedge clk) disable iff (rst) (!line_start && !adv_en) |=> $stable(pix_addr)); // R4
    AST_ADDR_STEP:   assert property (@(posedge clk) disable iff (rst) (!line_start && adv_en) |=> (pix_addr == ADDR_W'($past(pix_addr) + 1))); // R7
    AST_LINE_BASE:   assert property (@(posedge clk) disable iff (rst) line_start |=> (pix_addr == $past(line_base))); // R5
endmodule

bind pxs_stretch_top pxs_stretch_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_stb   (load_stb),
    .load_pat   (load_pat),
    .line_start (line_start),
    .line_base  (line_base),
    .adv_en     (adv_en),
    .pix_addr   (pix_addr),
    .ring_q     (ring_q)
);

// File: tb/test_pxs_stretch_top.sv
module test_pxs_stretch_top;
    localparam int CLK_P = 10;
    localparam int RW = 12;
    localparam int AW = 19;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_stb = 1'b0;
    logic [RW-1:0] load_pat = '0;
    logic          line_start = 1'b0;
    logic [AW-1:0] line_base = '0;
    logic          adv_en;
    logic [AW-1:0] pix_addr;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 0;

    // Reference state
    bit     mq[$];
    longint maddr;

    always #(CLK_P/2) clk = ~clk;

    pxs_stretch_top i_pxs_stretch_top (
        .clk(clk), .rst(rst), .load_stb(load_stb), .load_pat(load_pat),
        .line_start(line_start), .line_base(line_base),
        .adv_en(adv_en), .pix_addr(pix_addr)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Behavioural model updated at every edge
    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            for (int i = 0; i < RW; i++) mq.push_back(1'b1);
            maddr = 0;
        end else begin
            bit adv;
            bit b;
            adv = mq[0];
            if (line_start) maddr = line_base;
            else if (adv)   maddr = (maddr + 1) % (longint'(1) << AW);
            if (load_stb) begin
                mq.delete();
                for (int i = 0; i < RW; i++) mq.push_back(load_pat[i]);
            end else begin
                b = mq.pop_front();
                mq.push_back(b);
            end
        end
    end

    // Compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done && mq.size() == RW) begin
            check(adv_en == mq[0], "R3 adv_en vs model", adv_en, mq[0]);
            check(pix_addr == AW'(maddr), "R4 pix_addr vs model", pix_addr, maddr);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R6: load a pattern together with a line start, then measure address run lengths
    task automatic run_factor(input int n, input logic [RW-1:0] pat);
        logic [AW-1:0] prev;
        int run;
        int changes;
        @(negedge clk);
        load_stb = 1'b1; load_pat = pat;
        line_start = 1'b1; line_base = 19'h01000;
        @(negedge clk);
        load_stb = 1'b0; line_start = 1'b0;
        check(pix_addr == 19'h01000, "R8 base with load", pix_addr, 19'h01000);
        check(adv_en == pat[0], "R2 tap after load", adv_en, pat[0]);
        prev = pix_addr; run = 1; changes = 0;
        for (int c = 0; c < 48; c++) begin
            @(negedge clk);
            if (pix_addr != prev) begin
                if (changes > 0) check(run == n, "R6 hold length", run, n);
                changes++;
                run = 1;
                prev = pix_addr;
            end else begin
                run++;
            end
        end
        check(changes == 1 + (47 / n), "R6 advance count", changes, 1 + (47 / n));
    endtask

    initial begin
        rst = 1'b1;
        cyc(3);
        check(adv_en == 1'b1, "R1 adv_en in reset", adv_en, 1);
        check(pix_addr == '0, "R1 pix_addr in reset", pix_addr, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(pix_addr == 19'd1, "R1 first advance after reset", pix_addr, 1);

        run_factor(1, 12'hFFF);
        run_factor(2, 12'h555);
        run_factor(3, 12'h249);
        run_factor(4, 12'h111);
        run_factor(6, 12'h041);

        // R2/R3: irregular pattern reaches the tap bit by bit
        @(negedge clk); load_stb = 1'b1; load_pat = 12'hA5C;
        @(negedge clk); load_stb = 1'b0;
        for (int k = 0; k < 24; k++) begin
            check(adv_en == load_pat[k % RW], "R3 rotation order", adv_en, load_pat[k % RW]);
            @(negedge clk);
        end

        // R5: line start while advancing wins over the step
        @(negedge clk); load_stb = 1'b1; load_pat = 12'hFFF;
        @(negedge clk); load_stb = 1'b0; line_start = 1'b1; line_base = 19'h12345;
        @(negedge clk); line_start = 1'b0;
        check(pix_addr == 19'h12345, "R5 base over advance", pix_addr, 19'h12345);

        // R7: wrap at the top of the address range
        line_start = 1'b1; line_base = 19'h7FFFE;
        @(negedge clk); line_start = 1'b0;
        check(pix_addr == 19'h7FFFE, "R7 near top", pix_addr, 19'h7FFFE);
        @(negedge clk);
        check(pix_addr == 19'h7FFFF, "R7 top", pix_addr, 19'h7FFFF);
        @(negedge clk);
        check(pix_addr == 19'h00000, "R7 wrap", pix_addr, 0);

        // R1: reset mid-run restores state
        load_stb = 1'b1; load_pat = 12'h041;
        @(negedge clk); load_stb = 1'b0; rst = 1'b1;
        @(negedge clk);
        check(adv_en == 1'b1 && pix_addr == '0, "R1 reset mid-run", {adv_en, pix_addr}, {1'b1, 19'h0});
        rst = 1'b0;
        cyc(14);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule